// File: doc/BRIEF.md
# Sequential Repeated-Addition Multiplier

This block multiplies two 8-bit unsigned numbers with a single adder that it reuses over many cycles. A small controller accepts a start command while the block is idle. It loads the first operand as the multiplicand and the second operand as a down-counter, and it clears the product. It then adds the multiplicand into the product once per clock cycle until the counter runs out. When either operand is zero, a dedicated state clears the product and the block goes straight back to idle without running the loop.

The ready flag is high only while the controller is idle. The caller raises start for one cycle while ready is high, with both operands valid. The operands must stay valid for the following cycle as well, because that is the cycle in which they are sampled. The result can be read once ready returns high, and it stays on the output until the next accepted start or a reset.

Top module: `seq_mult`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the block in idle, with ready = 1 and product = 0, even in the middle of a multiplication.
- R2: Ready is 1 only in the idle state. Start is acted on only while ready is 1.
- R3: For nonzero operands, the edge that accepts start moves to a load step. At the next edge the multiplicand register takes op_a, the counter takes op_b, and product is cleared to 0. For that reason the operands must be held through the cycle after start.
- R4: In the operate step, each edge adds the multiplicand to product and lowers the counter by one, in the same cycle. The step ends when the counter reaches zero. For nonzero operands, ready is 0 for op_b + 1 cycles after the accepting edge, and product then equals op_a * op_b.
- R5: If op_a or op_b is 0 when start is accepted, the next edge clears product to 0 and returns to idle. Ready is 0 for exactly one cycle and no additions take place.
- R6: While idle and no start is given, product holds its value, even when op_a and op_b change.
- R7: A start pulse raised while ready is 0 has no effect. The multiplication in progress completes with its original operands and its original latency.
- R8: The largest operands (255 * 255) give the full 16-bit product 65025.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start command, one-cycle pulse while ready is high |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier and repeat count, unsigned |
| product | output | 16 | Product, unsigned |
| ready | output | 1 | High while idle and able to accept start |

## Verification
The bench measures how long ready stays low after each start and compares that with op_b + 1. A design with an off-by-one loop exit would show the wrong count, and its product would be one multiplicand too large or too small.

Zero in either operand must give a one-cycle bypass with product 0. A design that enters the loop with a zero count would wrap the counter and run for 256 cycles.

A start pulse in mid-run, with different operands, must not restart or corrupt the run. Changes to the operands while idle must not disturb a finished result. Finally, the product for 255 * 255 exposes a product register or adder that is too narrow.

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [2*W-1:0] product,
  output logic         ready
);
  localparam int PW = 2 * W;

  typedef enum logic [1:0] {S_IDLE, S_ZERO, S_LOAD, S_OPER} st_t;

  st_t           state_q, state_d;
  logic [W-1:0]  mcand_q, mcand_d;
  logic [W-1:0]  cnt_q, cnt_d;
  logic [PW-1:0] acc_q, acc_d;
  logic [PW-1:0] sum;
  logic          any_zero;

  assign any_zero = (op_a == '0) || (op_b == '0);
  assign sum      = acc_q + {{W{1'b0}}, mcand_q};
  assign ready    = (state_q == S_IDLE);
  assign product  = acc_q;

  always_comb begin
    state_d = state_q;
    mcand_d = mcand_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    unique case (state_q)
      S_IDLE: if (start) state_d = any_zero ? S_ZERO : S_LOAD;
      S_ZERO: begin
        acc_d   = '0;
        state_d = S_IDLE;
      end
      S_LOAD: begin
        mcand_d = op_a;
        cnt_d   = op_b;
        acc_d   = '0;
        state_d = S_OPER;
      end
      S_OPER: begin
        acc_d = sum;
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == W'(1)) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      acc_q   <= '0;
      mcand_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      acc_q   <= acc_d;
      mcand_q <= mcand_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

module seq_mult_chk #(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic [2*W-1:0] product,
  input logic          ready,
  input logic [1:0]    st,
  input logic [W-1:0]  cnt,
  input logic [W-1:0]  mcand
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (ready && product == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> (ready && $stable(product)));

  // R5
  zero_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && start && (op_a == '0 || op_b == '0)) |=> (!ready ##1 (ready && product == '0)));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd2) |=> (product == '0 && cnt == $past(op_b) && mcand == $past(op_a)));

  // R4
  accumulate_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd3) |=> (product == $past(product) + {{W{1'b0}}, $past(mcand)}
                      && cnt == $past(cnt) - 1'b1));

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (st == 2'd0));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd3 && cnt != W'(1)) |=> (st == 2'd3));
endmodule

bind seq_mult seq_mult_chk #(.W(W)) chk (
  .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
  .product(product), .ready(ready), .st(state_q), .cnt(cnt_q), .mcand(mcand_q)
);

// File: tb/seq_mult_test.sv
module seq_mult_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [7:0]  op_a = 0;
  logic [7:0]  op_b = 0;
  logic [15:0] product;
  logic        ready;
  int checks = 0;
  int fails = 0;

  seq_mult uut (.clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
                .product(product), .ready(ready));

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts a multiplication and measures the number of cycles ready stays low.
  task automatic mul(input int a, input int b, input bit pulse_busy, output int lat);
    @(negedge clk);
    op_a = 8'(a); op_b = 8'(b); start = 1;
    @(negedge clk);
    start = 0;
    lat = 0;
    while (!ready && lat < 400) begin
      lat++;
      if (pulse_busy && lat == 2) begin
        op_a = 8'd3; op_b = 8'd2; start = 1;
      end else begin
        start = 0;
        if (lat >= 2) begin op_a = 8'd0; op_b = 8'd0; end
      end
      @(negedge clk);
    end
    start = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset ready", ready, 1);
    chk("R1 reset product", product, 0);
  endtask

  task automatic t_basic(input int a, input int b);
    int lat;
    mul(a, b, 0, lat);
    chk("R4 product", product, a * b);
    chk("R4 latency", lat, b + 1);
  endtask

  task automatic t_zero(input int a, input int b);
    int lat;
    mul(a, b, 0, lat);
    chk("R5 zero product", product, 0);
    chk("R5 zero latency", lat, 1);
  endtask

  task automatic t_busy;
    int lat;
    mul(9, 6, 1, lat);
    chk("R7 busy start product", product, 54);
    chk("R7 busy start latency", lat, 7);
    chk("R2 ready after run", ready, 1);
  endtask

  task automatic t_hold;
    t_basic(12, 11);
    repeat (3) begin
      @(negedge clk);
      op_a = 8'd200; op_b = 8'd77;
    end
    @(negedge clk);
    chk("R6 idle hold", product, 132);
    chk("R2 idle ready", ready, 1);
  endtask

  task automatic t_load_clear;
    int lat;
    mul(1, 1, 0, lat);
    chk("R3 load clears old product", product, 1);
    chk("R3 latency single add", lat, 2);
  endtask

  task automatic t_max;
    t_basic(255, 255);
    chk("R8 full width", product, 65025);
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    op_a = 8'd20; op_b = 8'd30; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    chk("R2 busy ready low", ready, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 mid reset ready", ready, 1);
    chk("R1 mid reset product", product, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic(7, 5);
    t_basic(13, 1);
    t_basic(1, 200);
    t_zero(0, 9);
    t_zero(44, 0);
    t_zero(0, 0);
    t_busy();
    t_hold();
    t_load_clear();
    t_max();
    t_mid_reset();
    t_basic(6, 7);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule